// File: doc/BRIEF.md
# Sampling Phase Sweep Controller

This block drives the receive-clock tuning search of a high-speed SD/eMMC host. On a start request it decides first whether tuning is needed at all: a slow card clock, or a timing mode outside the two that need it, ends the request at once with success. Otherwise it asks a delay-line init sequencer to reset the delay line, then walks the sixteen sampling phases in turn. For each phase it has a phase programmer apply the setting, starts a tuning-block read, and checks the returned byte stream against a stored reference pattern.

Every phase whose read arrives with clean command and data flags, the exact byte count and a perfect byte match is appended to a pass list. A window selector downstream consumes that list. When a full sweep finds nothing, the block resets the delay line and sweeps again, up to a fixed number of attempts, and then gives up with an I/O failure. A timeout reported by either helper ends the request immediately with a timeout status.

Top module: `phase_sweep_ctrl`

## Requirements
- R1: When `clk_mhz_i` is at or below `BYPASS_MHZ` (100), or `timing_mode_i` is neither 3 (SDR104) nor 4 (HS200), a start raises `done_o` on the next cycle with `status_o` = 0 (success), no init or phase request is made, and `pass_cnt_o` reads 0.
- R2: Each attempt begins by holding `dll_init_req_o` high until `dll_init_ack_i`. An ack with `dll_init_err_i` high ends the request with `status_o` = 2 (timeout), and no phase is requested.
- R3: Within one attempt, phases 0 through `NUM_PHASES-1` (15) are requested in ascending order. `phase_req_o` stays high and `phase_val_o` stays stable until `phase_ack_i`. An ack with `phase_err_i` high ends the request with `status_o` = 2.
- R4: The reference is 128 bytes when `opcode_i` equals `HS200_TUNE_OP` (21) and `bus8_i` is high. In every other case it is 64 bytes.
- R5: Reference bytes come from 32-bit words, least significant byte first. The 64-byte pattern opens with words 0x00ff0fff, 0xccc3ccff and the 128-byte pattern with 0xff00ffff, 0x0000ffff.
- R6: A phase passes only when, at the `rd_end_i` cycle, `cmd_err_i` and `data_err_i` are low and exactly the reference length of beats (`rx_valid_i` before `rd_end_i`) were received, all equal to the reference. A short, long or corrupted stream or either error flag fails the phase.
- R7: A read with no `rd_end_i` within `TIMEOUT_CYC` cycles fails that phase, and the sweep continues with the next one.
- R8: Passing phases are recorded in discovery order, so the list is ascending. Entry k sits at `pass_list_o[4k+3:4k]` and `pass_cnt_o` counts the entries. Both are cleared by every start.
- R9: An attempt with no passing phase starts a new attempt, including a new init request, up to `MAX_ATTEMPTS` (3) attempts. After that, `status_o` = 1 (I/O failure) with `pass_cnt_o` = 0.
- R10: Once the last phase has been judged and at least one phase passed, `done_o` pulses with `status_o` = 0.
- R11: `dll_init_req_o`, `phase_req_o` and `rd_start_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a tuning request (taken when idle) |
| clk_mhz_i | input | CLK_MHZ_W | Card clock rate in MHz |
| timing_mode_i | input | 3 | Bus timing mode code |
| opcode_i | input | 6 | Tuning command index |
| bus8_i | input | 1 | 8-bit data bus in use |
| dll_init_req_o | output | 1 | Delay-line init request |
| dll_init_ack_i | input | 1 | Init finished |
| dll_init_err_i | input | 1 | Init timed out (valid with ack) |
| phase_req_o | output | 1 | Apply-phase request |
| phase_val_o | output | PHASE_W | Phase to apply |
| phase_ack_i | input | 1 | Phase applied |
| phase_err_i | input | 1 | Phase programming timed out (valid with ack) |
| rd_start_o | output | 1 | One-cycle pulse launching a tuning read |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| rd_end_i | input | 1 | Read finished, flags valid |
| cmd_err_i | input | 1 | Command error for this read |
| data_err_i | input | 1 | Data error for this read |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 success, 1 I/O failure, 2 timeout |
| pass_list_o | output | NUM_PHASES*PHASE_W | Passing phases, ascending |
| pass_cnt_o | output | PHASE_W+1 | Number of valid list entries |

## Verification
The bench keeps every default except `TIMEOUT_CYC`, which it sets to 300 cycles. That shortening puts the read timeout of R7 within a few hundred cycles next to full 128-byte reads. It sweeps a family of pass masks, with lone first and last phases among them, and rotates the failure kind across corrupted bytes, each error flag, and short and long streams. Because the card model can change its mask per attempt, the same arrangement reaches the second and third attempts, the final I/O failure, and both helper timeouts.

// File: rtl/phase_sweep_pkg.sv
// Shared types and the tuning reference patterns for the phase sweep block.
// Assumes: patterns are fixed by the card standard and never change at run time.
package phase_sweep_pkg;

    typedef enum logic [1:0] {
        SWEEP_OK      = 2'd0,
        SWEEP_IO_FAIL = 2'd1,
        SWEEP_TIMEOUT = 2'd2
    } sweep_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DLL,
        ST_PHASE,
        ST_READ
    } sweep_state_e;

    localparam logic [2:0] MODE_SDR104 = 3'd3;
    localparam logic [2:0] MODE_HS200  = 3'd4;

    localparam int NARROW_BYTES = 64;
    localparam int WIDE_BYTES   = 128;

    // Reference word lookup: wide selects the 128-byte pattern, idx is the word number.
    function automatic logic [31:0] pattern_word(input logic wide, input logic [4:0] idx);
        logic [31:0] w;
        w = 32'h0;
        if (!wide) begin
            case (idx)
                5'd0:  w = 32'h00ff0fff;  5'd1:  w = 32'hccc3ccff;
                5'd2:  w = 32'hffcc3cc3;  5'd3:  w = 32'heffefffe;
                5'd4:  w = 32'hddffdfff;  5'd5:  w = 32'hfbfffbff;
                5'd6:  w = 32'hff7fffbf;  5'd7:  w = 32'hefbdf777;
                5'd8:  w = 32'hf0fff0ff;  5'd9:  w = 32'h3cccfc0f;
                5'd10: w = 32'hcfcc33cc;  5'd11: w = 32'heeffefff;
                5'd12: w = 32'hfdfffdff;  5'd13: w = 32'hffbfffdf;
                5'd14: w = 32'hfff7ffbb;  5'd15: w = 32'hde7b7ff7;
                default: w = 32'h0;
            endcase
        end else begin
            case (idx)
                5'd0:  w = 32'hff00ffff;  5'd1:  w = 32'h0000ffff;
                5'd2:  w = 32'hccccffff;  5'd3:  w = 32'hcccc33cc;
                5'd4:  w = 32'hcc3333cc;  5'd5:  w = 32'hffffcccc;
                5'd6:  w = 32'hffffeeff;  5'd7:  w = 32'hffeeeeff;
                5'd8:  w = 32'hffddffff;  5'd9:  w = 32'hddddffff;
                5'd10: w = 32'hbbffffff;  5'd11: w = 32'hbbffffff;
                5'd12: w = 32'hffffffbb;  5'd13: w = 32'hffffff77;
                5'd14: w = 32'h77ff7777;  5'd15: w = 32'hffeeddbb;
                5'd16: w = 32'h00ffffff;  5'd17: w = 32'h00ffffff;
                5'd18: w = 32'hccffff00;  5'd19: w = 32'hcc33cccc;
                5'd20: w = 32'h3333cccc;  5'd21: w = 32'hffcccccc;
                5'd22: w = 32'hffeeffff;  5'd23: w = 32'heeeeffff;
                5'd24: w = 32'hddffffff;  5'd25: w = 32'hddffffff;
                5'd26: w = 32'hffffffdd;  5'd27: w = 32'hffffffbb;
                5'd28: w = 32'hffffbbbb;  5'd29: w = 32'hffff77ff;
                5'd30: w = 32'hff7777ff;  5'd31: w = 32'heeddbb77;
                default: w = 32'h0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/sweep_pattern_rom.sv
// Byte-addressed view of the reference patterns.
// Assumes: byte_idx_i < pattern length; bytes leave each word LSB first.
module sweep_pattern_rom
    import phase_sweep_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             wide_i,
    input  logic [IDX_W-1:0] byte_idx_i,
    output logic [7:0]       ref_byte_o
);

    logic [31:0] word;

    // Select the word, then the byte lane inside it
    always_comb begin
        word       = pattern_word(wide_i, byte_idx_i[6:2]);
        ref_byte_o = word[{byte_idx_i[1:0], 3'b000} +: 8];
    end

endmodule

// File: rtl/sweep_beat_checker.sv
// Counts received bytes of one tuning read and flags any difference from the reference.
// Assumes: clear_i pulses before the first beat; bytes past the pattern length are errors.
module sweep_beat_checker
    import phase_sweep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             beat_valid_i,
    input  logic [7:0]       beat_i,
    input  logic             wide_i,
    output logic [CNT_W-1:0] count_o,
    output logic             mismatch_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic             mismatch_q;
    logic [CNT_W-1:0] len;
    logic [7:0]       ref_byte;

    assign len = wide_i ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES);

    sweep_pattern_rom #(.IDX_W(7)) u_rom (
        .wide_i     (wide_i),
        .byte_idx_i (count_q[6:0]),
        .ref_byte_o (ref_byte)
    );

    // Track the beat count and a sticky mismatch for the current read
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q    <= '0;
            mismatch_q <= 1'b0;
        end else if (beat_valid_i) begin
            if (count_q >= len || beat_i != ref_byte) mismatch_q <= 1'b1;
            if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
        end
    end

    assign count_o    = count_q;
    assign mismatch_o = mismatch_q;

endmodule

// File: rtl/sweep_read_timer.sv
// Measures how long the current tuning read has been outstanding.
// Assumes: run_i is high exactly while a read is awaited; dropping it resets the count.
module sweep_read_timer #(
    parameter int LIMIT = 50_000_000,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    logic [W-1:0] cnt_q;

    // Count up while running, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)          cnt_q <= '0;
        else if (cnt_q != W'(LIMIT))   cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == W'(LIMIT));

endmodule

// File: rtl/sweep_pass_list.sv
// Ordered list of passing phases, filled in discovery order.
// Assumes: at most N pushes between clears; extra pushes are dropped.
module sweep_pass_list #(
    parameter int N  = 16,
    parameter int PW = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            push_i,
    input  logic [PW-1:0]   phase_i,
    output logic [N*PW-1:0] list_o,
    output logic [CW-1:0]   cnt_o
);

    logic [CW-1:0] cnt_q;

    // Advance the fill count on each accepted push
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)                cnt_q <= '0;
        else if (push_i && cnt_q != CW'(N))   cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic [PW-1:0] entry_q;
        // Capture the pushed phase into the slot the count points at
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)                   entry_q <= '0;
            else if (push_i && cnt_q == CW'(g))      entry_q <= phase_i;
        end
        assign list_o[g*PW +: PW] = entry_q;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/phase_sweep_ctrl.sv
// Top of the sampling phase sweep: bypass decision, init/phase handshakes,
// per-phase tuning read judgement, pass recording and attempt retry.
// Assumes: rd_end_i arrives in a cycle after the last rx_valid_i beat; helper
// acks are single-cycle and only answer a raised request.
module phase_sweep_ctrl
    import phase_sweep_pkg::*;
#(
    parameter int NUM_PHASES    = 16,
    parameter int MAX_ATTEMPTS  = 3,
    parameter int TIMEOUT_CYC   = 50_000_000,
    parameter int CLK_MHZ_W     = 10,
    parameter int BYPASS_MHZ    = 100,
    parameter int HS200_TUNE_OP = 21,
    localparam int PHASE_W      = $clog2(NUM_PHASES),
    localparam int CNT_W        = 8,
    localparam int ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [CLK_MHZ_W-1:0]          clk_mhz_i,
    input  logic [2:0]                    timing_mode_i,
    input  logic [5:0]                    opcode_i,
    input  logic                          bus8_i,
    output logic                          dll_init_req_o,
    input  logic                          dll_init_ack_i,
    input  logic                          dll_init_err_i,
    output logic                          phase_req_o,
    output logic [PHASE_W-1:0]            phase_val_o,
    input  logic                          phase_ack_i,
    input  logic                          phase_err_i,
    output logic                          rd_start_o,
    input  logic                          rx_valid_i,
    input  logic [7:0]                    rx_byte_i,
    input  logic                          rd_end_i,
    input  logic                          cmd_err_i,
    input  logic                          data_err_i,
    output logic                          done_o,
    output logic [1:0]                    status_o,
    output logic [NUM_PHASES*PHASE_W-1:0] pass_list_o,
    output logic [PHASE_W:0]              pass_cnt_o
);

    sweep_state_e         state_q;
    logic [PHASE_W-1:0]   phase_q;
    logic [ATT_W-1:0]     attempt_q;
    logic                 wide_q;
    logic                 done_q;
    sweep_status_e        status_q;
    logic                 rd_start_q;

    logic                 bypass;
    logic                 in_read;
    logic                 tmr_expired;
    logic                 read_over;
    logic                 pass_now;
    logic                 last_phase;
    logic                 last_attempt;
    logic                 any_pass;
    logic                 chk_clear;
    logic                 list_clear;
    logic [CNT_W-1:0]     beat_cnt;
    logic                 beat_bad;
    logic [CNT_W-1:0]     ref_len;

    // Bypass decision and per-read judgement
    always_comb begin
        bypass       = (clk_mhz_i <= CLK_MHZ_W'(BYPASS_MHZ)) ||
                       !(timing_mode_i == MODE_SDR104 || timing_mode_i == MODE_HS200);
        in_read      = (state_q == ST_READ);
        ref_len      = wide_q ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES);
        read_over    = in_read && (rd_end_i || tmr_expired);
        pass_now     = in_read && rd_end_i && !cmd_err_i && !data_err_i &&
                       !beat_bad && (beat_cnt == ref_len);
        last_phase   = (phase_q == PHASE_W'(NUM_PHASES - 1));
        last_attempt = (attempt_q == ATT_W'(MAX_ATTEMPTS - 1));
        any_pass     = (pass_cnt_o != '0) || pass_now;
        chk_clear    = (state_q == ST_PHASE) && phase_ack_i;
        list_clear   = (state_q == ST_IDLE) && start_i;
    end

    sweep_beat_checker #(.CNT_W(CNT_W)) u_beats (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (chk_clear),
        .beat_valid_i (rx_valid_i && in_read),
        .beat_i       (rx_byte_i),
        .wide_i       (wide_q),
        .count_o      (beat_cnt),
        .mismatch_o   (beat_bad)
    );

    sweep_read_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_read),
        .expired_o (tmr_expired)
    );

    sweep_pass_list #(.N(NUM_PHASES), .PW(PHASE_W)) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (list_clear),
        .push_i  (pass_now),
        .phase_i (phase_q),
        .list_o  (pass_list_o),
        .cnt_o   (pass_cnt_o)
    );

    // Sweep sequencer: init, per-phase program/read, retry and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_q    <= '0;
            attempt_q  <= '0;
            wide_q     <= 1'b0;
            done_q     <= 1'b0;
            status_q   <= SWEEP_OK;
            rd_start_q <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            rd_start_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        wide_q    <= (opcode_i == 6'(HS200_TUNE_OP)) && bus8_i;
                        attempt_q <= '0;
                        if (bypass) begin
                            done_q   <= 1'b1;
                            status_q <= SWEEP_OK;
                        end else begin
                            state_q <= ST_DLL;
                        end
                    end
                end
                ST_DLL: begin
                    if (dll_init_ack_i) begin
                        if (dll_init_err_i) begin
                            done_q   <= 1'b1;
                            status_q <= SWEEP_TIMEOUT;
                            state_q  <= ST_IDLE;
                        end else begin
                            phase_q <= '0;
                            state_q <= ST_PHASE;
                        end
                    end
                end
                ST_PHASE: begin
                    if (phase_ack_i) begin
                        if (phase_err_i) begin
                            done_q   <= 1'b1;
                            status_q <= SWEEP_TIMEOUT;
                            state_q  <= ST_IDLE;
                        end else begin
                            rd_start_q <= 1'b1;
                            state_q    <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (read_over) begin
                        if (!last_phase) begin
                            phase_q <= phase_q + 1'b1;
                            state_q <= ST_PHASE;
                        end else if (any_pass) begin
                            done_q   <= 1'b1;
                            status_q <= SWEEP_OK;
                            state_q  <= ST_IDLE;
                        end else if (last_attempt) begin
                            done_q   <= 1'b1;
                            status_q <= SWEEP_IO_FAIL;
                            state_q  <= ST_IDLE;
                        end else begin
                            attempt_q <= attempt_q + 1'b1;
                            state_q   <= ST_DLL;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dll_init_req_o = (state_q == ST_DLL);
    assign phase_req_o    = (state_q == ST_PHASE);
    assign phase_val_o    = phase_q;
    assign rd_start_o     = rd_start_q;
    assign done_o         = done_q;
    assign status_o       = status_q;

endmodule

// File: rtl/phase_sweep_chk.sv
// Port-level protocol checks for phase_sweep_ctrl, attached by bind.
// Assumes: helpers answer only raised requests.
module phase_sweep_chk #(
    parameter int NUM_PHASES = 16,
    parameter int PHASE_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dll_init_req_o,
    input logic               dll_init_ack_i,
    input logic               phase_req_o,
    input logic [PHASE_W-1:0] phase_val_o,
    input logic               phase_ack_i,
    input logic               rd_start_o,
    input logic               done_o,
    input logic [1:0]         status_o,
    input logic [PHASE_W:0]   pass_cnt_o
);

    // R11
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dll_init_req_o, phase_req_o, rd_start_o}));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req_o && !phase_ack_i) |=> (phase_req_o && $stable(phase_val_o)));

    // R2
    dll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_init_req_o && !dll_init_ack_i) |=> dll_init_req_o);

    // R8
    list_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_cnt_o <= (PHASE_W+1)'(NUM_PHASES));

    // R9
    iofail_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd1) |-> (pass_cnt_o == '0));

    // R10
    ok_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd0 && pass_cnt_o != '0) |-> !phase_req_o);

endmodule

bind phase_sweep_ctrl phase_sweep_chk #(
    .NUM_PHASES (NUM_PHASES),
    .PHASE_W    (PHASE_W)
) u_sweep_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dll_init_req_o (dll_init_req_o),
    .dll_init_ack_i (dll_init_ack_i),
    .phase_req_o    (phase_req_o),
    .phase_val_o    (phase_val_o),
    .phase_ack_i    (phase_ack_i),
    .rd_start_o     (rd_start_o),
    .done_o         (done_o),
    .status_o       (status_o),
    .pass_cnt_o     (pass_cnt_o)
);

// File: tb/test_phase_sweep_ctrl.sv
module test_phase_sweep_ctrl;

    localparam int TMO = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  clk_mhz_i = 10'd200;
    logic [2:0]  timing_mode_i = 3'd4;
    logic [5:0]  opcode_i = 6'd19;
    logic        bus8_i = 1'b0;
    logic        dll_init_req_o, dll_init_ack_i = 1'b0, dll_init_err_i = 1'b0;
    logic        phase_req_o, phase_ack_i = 1'b0, phase_err_i = 1'b0;
    logic [3:0]  phase_val_o;
    logic        rd_start_o;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_byte_i = 8'h0;
    logic        rd_end_i = 1'b0, cmd_err_i = 1'b0, data_err_i = 1'b0;
    logic        done_o;
    logic [1:0]  status_o;
    logic [63:0] pass_list_o;
    logic [4:0]  pass_cnt_o;

    always #10 clk = ~clk;

    phase_sweep_ctrl #(.TIMEOUT_CYC(TMO)) i_phase_sweep_ctrl (.*);

    // Bench-side copies of the reference patterns
    logic [31:0] pat_n [16] = '{
        32'h00ff0fff, 32'hccc3ccff, 32'hffcc3cc3, 32'heffefffe,
        32'hddffdfff, 32'hfbfffbff, 32'hff7fffbf, 32'hefbdf777,
        32'hf0fff0ff, 32'h3cccfc0f, 32'hcfcc33cc, 32'heeffefff,
        32'hfdfffdff, 32'hffbfffdf, 32'hfff7ffbb, 32'hde7b7ff7};
    logic [31:0] pat_w [32] = '{
        32'hff00ffff, 32'h0000ffff, 32'hccccffff, 32'hcccc33cc,
        32'hcc3333cc, 32'hffffcccc, 32'hffffeeff, 32'hffeeeeff,
        32'hffddffff, 32'hddddffff, 32'hbbffffff, 32'hbbffffff,
        32'hffffffbb, 32'hffffff77, 32'h77ff7777, 32'hffeeddbb,
        32'h00ffffff, 32'h00ffffff, 32'hccffff00, 32'hcc33cccc,
        32'h3333cccc, 32'hffcccccc, 32'hffeeffff, 32'heeeeffff,
        32'hddffffff, 32'hddffffff, 32'hffffffdd, 32'hffffffbb,
        32'hffffbbbb, 32'hffff77ff, 32'hff7777ff, 32'heeddbb77};

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Card / helper model configuration
    logic [15:0] good_mask [3];
    int  fault_kind = 1;
    bit  send_wide = 1'b0;
    bit  cfg_dll_err = 1'b0;
    int  cfg_ph_err_at = -1;
    int  dll_cnt = 0;
    int  log_n = 0;
    int  phase_log [64];
    int  cur_phase = 0;

    function automatic logic [7:0] ref_byte(bit wide, int i);
        logic [31:0] w;
        w = wide ? pat_w[(i >> 2) % 32] : pat_n[(i >> 2) % 16];
        return w[8*(i % 4) +: 8];
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Stream one tuning read answer for the current phase
    task automatic answer_read();
        int  len;
        int  n;
        int  att;
        bit  good;
        logic [7:0] b;
        len  = send_wide ? 128 : 64;
        att  = (dll_cnt > 0) ? ((dll_cnt - 1) % 3) : 0;
        good = good_mask[att][cur_phase];
        if (!good && fault_kind == 6) return;
        n = len;
        if (!good && fault_kind == 4) n = len - 1;
        if (!good && fault_kind == 5) n = len + 1;
        for (int i = 0; i < n; i++) begin
            b = ref_byte(send_wide, i % len);
            if (!good && fault_kind == 1 && i == (cur_phase * 5) % len) b = b ^ 8'h10;
            rx_valid_i = 1'b1;
            rx_byte_i  = b;
            @(negedge clk);
        end
        rx_valid_i = 1'b0;
        rd_end_i   = 1'b1;
        cmd_err_i  = !good && fault_kind == 2;
        data_err_i = !good && fault_kind == 3;
        @(negedge clk);
        rd_end_i   = 1'b0;
        cmd_err_i  = 1'b0;
        data_err_i = 1'b0;
    endtask

    // Responder for init, phase and read requests
    initial begin
        forever begin
            @(negedge clk);
            dll_init_ack_i = 1'b0;
            dll_init_err_i = 1'b0;
            phase_ack_i    = 1'b0;
            phase_err_i    = 1'b0;
            if (dll_init_req_o) begin
                dll_init_ack_i = 1'b1;
                dll_init_err_i = cfg_dll_err;
                dll_cnt++;
            end else if (phase_req_o) begin
                phase_ack_i = 1'b1;
                phase_err_i = (int'(phase_val_o) == cfg_ph_err_at);
                cur_phase   = int'(phase_val_o);
                if (log_n < 64) phase_log[log_n] = cur_phase;
                log_n++;
            end else if (rd_start_o) begin
                answer_read();
            end
        end
    end

    int wait_cyc;

    task automatic run(int mhz, int mode, int op, bit w8);
        dll_cnt = 0;
        log_n   = 0;
        clk_mhz_i     = 10'(mhz);
        timing_mode_i = 3'(mode);
        opcode_i      = 6'(op);
        bus8_i        = w8;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        wait_cyc = 0;
        while (!done_o && wait_cyc < 40000) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (!done_o) chk("watchdog: done_o never rose", 0, 1);
    endtask

    function automatic int popcnt(logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += m[i];
        return c;
    endfunction

    // Compare the pass list against the ascending bit positions of a mask
    task automatic chk_list(string tag, logic [15:0] m);
        int k = 0;
        chk({tag, " pass count"}, int'(pass_cnt_o), popcnt(m));
        for (int p = 0; p < 16; p++) begin
            if (m[p]) begin
                chk({tag, " pass entry"}, int'(pass_list_o[4*k +: 4]), p);
                k++;
            end
        end
    endtask

    task automatic chk_order(string tag, int n);
        chk({tag, " phase requests"}, log_n, n);
        for (int i = 0; i < n && i < 64; i++)
            chk({tag, " phase order"}, phase_log[i], i % 16);
    endtask

    task automatic set_mask(logic [15:0] a, logic [15:0] b, logic [15:0] c);
        good_mask[0] = a;
        good_mask[1] = b;
        good_mask[2] = c;
    endtask

    // Global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] m;
        set_mask(16'hFFFF, 16'hFFFF, 16'hFFFF);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R11 reset dll_init_req_o", int'(dll_init_req_o), 0);
        chk("R11 reset phase_req_o", int'(phase_req_o), 0);
        chk("R10 reset done_o", int'(done_o), 0);
        chk("R8 reset pass_cnt_o", int'(pass_cnt_o), 0);

        // R1: bypass at exactly 100 MHz, and for a non-tuning mode
        run(100, 4, 21, 1'b1);
        chk("R1 bypass clk done delay", wait_cyc, 0);
        chk("R1 bypass clk status", int'(status_o), 0);
        chk("R1 bypass clk no init", dll_cnt, 0);
        chk("R1 bypass clk pass count", int'(pass_cnt_o), 0);
        run(200, 2, 19, 1'b0);
        chk("R1 bypass mode done delay", wait_cyc, 0);
        chk("R1 bypass mode no init", dll_cnt, 0);
        chk("R1 bypass mode no phase", log_n, 0);

        // R3 R5 R8 R10: full 64-byte pass at 101 MHz, SDR104
        send_wide = 1'b0;
        set_mask(16'hFFFF, 16'hFFFF, 16'hFFFF);
        run(101, 3, 19, 1'b0);
        chk("R10 full sweep status", int'(status_o), 0);
        chk("R2 single init", dll_cnt, 1);
        chk_order("R3 full", 16);
        chk_list("R8 full", 16'hFFFF);

        // R6 R8: mask family with rotating failure kinds
        for (int k = 0; k < 14; k++) begin
            m = 16'((k * 16'h3A5B) ^ (16'h1 << k) ^ (k << 9));
            if (k == 12) m = 16'h0001;
            if (k == 13) m = 16'h8000;
            if (m == 16'h0) m = 16'h0100;
            set_mask(m, m, m);
            fault_kind = 1 + (k % 5);
            run(200, 4, 19, 1'b0);
            chk("R6 mask sweep status", int'(status_o), 0);
            chk("R9 mask sweep one attempt", dll_cnt, 1);
            chk_order("R3 mask", 16);
            chk_list("R6 R8 mask", m);
        end

        // R4 R5: 128-byte pattern only for opcode 21 with 8-bit bus
        fault_kind = 1;
        set_mask(16'hFFFF, 16'hFFFF, 16'hFFFF);
        send_wide = 1'b1;
        run(200, 4, 21, 1'b1);
        chk("R4 wide status", int'(status_o), 0);
        chk_list("R4 R5 wide", 16'hFFFF);
        send_wide = 1'b0;
        run(200, 4, 21, 1'b0);
        chk_list("R4 op21 narrow bus uses 64", 16'hFFFF);
        run(200, 4, 19, 1'b1);
        chk_list("R4 wide bus other op uses 64", 16'hFFFF);
        run(200, 4, 21, 1'b1);
        chk("R4 64 bytes rejected when 128 expected", int'(status_o), 1);
        chk("R4 retries when 128 expected", dll_cnt, 3);

        // R9: pass appears only on the third attempt
        fault_kind = 3;
        set_mask(16'h0000, 16'h0000, 16'h0F00);
        run(200, 3, 19, 1'b0);
        chk("R9 third attempt status", int'(status_o), 0);
        chk("R9 third attempt inits", dll_cnt, 3);
        chk_order("R9 retry", 48);
        chk_list("R9 R8 retry", 16'h0F00);
        set_mask(16'h0000, 16'h0030, 16'hFFFF);
        run(200, 3, 19, 1'b0);
        chk("R9 second attempt inits", dll_cnt, 2);
        chk_list("R9 second", 16'h0030);

        // R9: never passes
        set_mask(16'h0000, 16'h0000, 16'h0000);
        fault_kind = 2;
        run(200, 4, 19, 1'b0);
        chk("R9 exhausted status", int'(status_o), 1);
        chk("R9 exhausted inits", dll_cnt, 3);
        chk("R9 exhausted pass count", int'(pass_cnt_o), 0);
        chk_order("R9 exhausted", 48);

        // R7: read with no end on phases 0 and 9
        set_mask(16'hFDFE, 16'hFDFE, 16'hFDFE);
        fault_kind = 6;
        run(200, 4, 19, 1'b0);
        chk("R7 timeout sweep status", int'(status_o), 0);
        chk_order("R7 timeout", 16);
        chk_list("R7 timeout", 16'hFDFE);

        // R2: init timeout
        set_mask(16'hFFFF, 16'hFFFF, 16'hFFFF);
        cfg_dll_err = 1'b1;
        run(200, 4, 19, 1'b0);
        chk("R2 init error status", int'(status_o), 2);
        chk("R2 init error no phase", log_n, 0);
        cfg_dll_err = 1'b0;

        // R3: phase programming timeout at phase 5
        cfg_ph_err_at = 5;
        run(200, 4, 19, 1'b0);
        chk("R3 phase error status", int'(status_o), 2);
        chk("R3 phase error requests", log_n, 6);
        chk("R3 phase error passes kept", int'(pass_cnt_o), 5);
        cfg_ph_err_at = -1;

        // R8: a later bypass start clears the list
        run(50, 4, 19, 1'b0);
        chk("R8 cleared by start", int'(pass_cnt_o), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule